// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a small processor core and decides which of five interrupt requests is taken, and when. The inputs have a fixed rank. The top input is a trap line that nothing can mask. Below it are three restart lines, ranked from high to low as an edge-latched line (level 7), then two level-sensitive lines (level 6 and level 5). At the bottom is a general request line. The three restart lines each have a mask bit. These mask bits are loaded through a mask-write port. A global enable gates every line except the trap. Dedicated strobes set and clear the global enable.

When a vectored source wins, the controller runs a short sequence. First it requests a push of the program counter it sampled. In the next cycle it presents the fixed restart address. When the general request wins, the controller produces no address. Instead it asserts an acknowledge for one cycle, captures the instruction byte on the data bus at the end of that cycle, and presents that byte in the next cycle. Taking any interrupt clears the global enable.

The sequencer has five states:
- IDLE: arbitrates.
- PUSH: asserts the push request.
- VEC: presents the restart address.
- ACK: asserts the acknowledge.
- FETCH: presents the captured byte.

Its transitions are:
- IDLE->PUSH when a vectored source is taken.
- IDLE->ACK when the general request is taken.
- PUSH->VEC.
- VEC->IDLE.
- ACK->FETCH.
- FETCH->IDLE.

Requests are examined only in IDLE.

Top module: `irq_vec_ctrl`

## Requirements
- R1: From highest to lowest, the rank is trap, level 7, level 6, level 5, general request. Among the eligible requests, only the highest-ranked one is taken in a cycle. An eligible request is taken at the first clock edge the controller spends in IDLE.
- R2: The trap line is taken whenever it is high in IDLE, whatever the global enable and the mask bits hold.
- R3: The restart addresses are trap 0x0024, level 5 0x002C, level 6 0x0034 and level 7 0x003C. `vec_valid` is high for exactly one cycle, and that cycle is the one right after `push_req`.
- R4: For a vectored source, `push_req` is high for one cycle, namely the cycle after the edge at which the source was taken. During that cycle `push_pc` equals the value `pc_in` had at that edge.
- R5: After reset, `int_en` is 0. `ei_stb` sets it at the next edge and `di_stb` clears it. When both strobes arrive together, the clear wins. Levels 5, 6 and 7 and the general request are eligible only while `int_en` is 1.
- R6: Taking any interrupt clears `int_en` at that same edge, even if `ei_stb` is high in that cycle. `int_en` then stays 0 until a later `ei_stb`.
- R7: A write with `mask_wr` high and `mask_wdata[3]` = 1 loads the mask bits. Bit 0 masks level 5, bit 1 masks level 6 and bit 2 masks level 7, and a 1 blocks the line. A write with bit 3 = 0 leaves the masks unchanged. After reset, all three lines are masked.
- R8: A rising edge on `edge7_req` sets a pending latch, even while level 7 is masked or the global enable is off. The latch holds after the input falls. Taking level 7 clears it, and so does a write with `mask_wr` high and `mask_wdata[4]` = 1, whatever bit 3 holds.
- R9: When the general request is taken, no push and no address appear. `inta` is high for one cycle, the cycle after the edge at which the request was taken. `data_in` is sampled at the end of that cycle, and in the following cycle `op_valid` is high with that byte on `op_byte`.
- R10: Level 5, level 6 and the general request are not remembered. A request that falls before it becomes eligible is never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Non-maskable request, level |
| edge7_req | input | 1 | Level 7 request, latched on its rising edge |
| lvl6_req | input | 1 | Level 6 request, level |
| lvl5_req | input | 1 | Level 5 request, level |
| intr_req | input | 1 | General request, level, byte-fetch acknowledge |
| ei_stb | input | 1 | Sets the global enable |
| di_stb | input | 1 | Clears the global enable |
| mask_wr | input | 1 | Mask-write strobe |
| mask_wdata | input | 5 | Mask-write data: [2:0] masks, [3] arm, [4] clear level 7 latch |
| pc_in | input | ADDR_W | Current program counter |
| data_in | input | DATA_W | Data bus, sampled during acknowledge |
| push_req | output | 1 | Request to push `push_pc` to the stack |
| push_pc | output | ADDR_W | Program counter to save |
| vec_valid | output | 1 | Restart address valid |
| vec_addr | output | ADDR_W | Restart address |
| inta | output | 1 | General-request acknowledge |
| op_valid | output | 1 | Fetched byte valid |
| op_byte | output | DATA_W | Byte fetched during acknowledge |
| int_en | output | 1 | Global enable state |

## Verification
The hardest case to reach is level 7 arriving at the same edge as lower-ranked levels. The line is edge-latched, so its pending bit exists only one cycle after its input rises. The sweep therefore raises `edge7_req` one cycle ahead of the other lines, so that all five contenders meet at a single arbitration edge. The sweep covers every request pattern, every mask setting and both enable states. The remaining directed runs keep a masked level 7 latch alive across several cycles, then either clear it with a write or release it by unmasking. They also make a strobe coincide with an acceptance, so that the clear-wins rule becomes visible on `int_en`.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC      = 5;
    localparam int NMASK     = 3;
    localparam int MW_W      = 5;
    localparam int MW_ARM    = 3;   // mask bits load only when this bit is 1
    localparam int MW_CLR7   = 4;   // clears the level 7 pending latch

    // Rank order: a higher code wins.
    typedef enum logic [2:0] {
        SRC_INTR = 3'd0,
        SRC_L5   = 3'd1,
        SRC_L6   = 3'd2,
        SRC_L7   = 3'd3,
        SRC_TRAP = 3'd4
    } src_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_VEC,
        ST_ACK,
        ST_FETCH
    } st_e;

    // Restart addresses sit 8 bytes apart: level n maps to 8*n + 4.
    function automatic logic [15:0] restart_addr(input src_e s);
        logic [15:0] a;
        unique case (s)
            SRC_TRAP: a = 16'h0024;
            SRC_L5, SRC_L6, SRC_L7:
                a = 16'(((int'(s) + 4) * 8) + 4);
            default:  a = 16'h0000;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/irq_gate_regs.sv
module irq_gate_regs
    import irq_pkg::*;
#(
    parameter int NM = NMASK
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ei_stb,
    input  logic            di_stb,
    input  logic            take,
    input  logic            take_l7,
    input  logic            mask_wr,
    input  logic [MW_W-1:0] mask_wdata,
    input  logic            l7_in,
    output logic            ien,
    output logic [NM-1:0]   mask,
    output logic            l7_pend
);

    logic l7_prev;
    logic l7_rise;
    logic l7_clr;

    assign l7_rise = l7_in & ~l7_prev;
    assign l7_clr  = take_l7 | (mask_wr & mask_wdata[MW_CLR7]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien     <= 1'b0;
            mask    <= '1;
            l7_prev <= 1'b0;
            l7_pend <= 1'b0;
        end else begin
            if (take || di_stb)
                ien <= 1'b0;
            else if (ei_stb)
                ien <= 1'b1;

            if (mask_wr && mask_wdata[MW_ARM])
                mask <= mask_wdata[NM-1:0];

            l7_prev <= l7_in;

            if (l7_clr)
                l7_pend <= 1'b0;
            else if (l7_rise)
                l7_pend <= 1'b1;
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N  = 5,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i])
                idx = IW'(i);
        end
    end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic              edge7_req,
    input  logic              lvl6_req,
    input  logic              lvl5_req,
    input  logic              intr_req,
    input  logic              ei_stb,
    input  logic              di_stb,
    input  logic              mask_wr,
    input  logic [MW_W-1:0]   mask_wdata,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              push_req,
    output logic [ADDR_W-1:0] push_pc,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              inta,
    output logic              op_valid,
    output logic [DATA_W-1:0] op_byte,
    output logic              int_en
);

    localparam int IW = $clog2(NSRC);

    st_e               state, state_nx;
    src_e              src_q, win_src;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] byte_q;
    logic              ien, l7_pend;
    logic [NMASK-1:0]  mask;
    logic [NSRC-1:0]   elig;
    logic              win_any, accept, take_l7;
    logic [IW-1:0]     win_idx;

    irq_gate_regs #(.NM(NMASK)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .ei_stb     (ei_stb),
        .di_stb     (di_stb),
        .take       (accept),
        .take_l7    (take_l7),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .l7_in      (edge7_req),
        .ien        (ien),
        .mask       (mask),
        .l7_pend    (l7_pend)
    );

    always_comb begin
        elig[SRC_TRAP] = trap_req;
        elig[SRC_L7]   = ien & ~mask[2] & l7_pend;
        elig[SRC_L6]   = ien & ~mask[1] & lvl6_req;
        elig[SRC_L5]   = ien & ~mask[0] & lvl5_req;
        elig[SRC_INTR] = ien & intr_req;
    end

    irq_arbiter #(.N(NSRC)) u_arb (
        .req (elig),
        .any (win_any),
        .idx (win_idx)
    );

    assign win_src = src_e'(win_idx);
    assign accept  = (state == ST_IDLE) && win_any;
    assign take_l7 = accept && (win_src == SRC_L7);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept)
                          state_nx = (win_src == SRC_INTR) ? ST_ACK : ST_PUSH;
            ST_PUSH:  state_nx = ST_VEC;
            ST_VEC:   state_nx = ST_IDLE;
            ST_ACK:   state_nx = ST_FETCH;
            ST_FETCH: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Captured context: winner, program counter, fetched byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_INTR;
            pc_q   <= '0;
            byte_q <= '0;
        end else begin
            if (accept) begin
                src_q <= win_src;
                pc_q  <= pc_in;
            end
            if (state == ST_ACK)
                byte_q <= data_in;
        end
    end

    // Outputs decoded from state
    always_comb begin
        push_req  = 1'b0;
        vec_valid = 1'b0;
        inta      = 1'b0;
        op_valid  = 1'b0;
        vec_addr  = '0;
        unique case (state)
            ST_IDLE:  ;
            ST_PUSH:  push_req = 1'b1;
            ST_VEC: begin
                vec_valid = 1'b1;
                vec_addr  = ADDR_W'(restart_addr(src_q));
            end
            ST_ACK:   inta = 1'b1;
            ST_FETCH: op_valid = 1'b1;
            default:  ;
        endcase
    end

    assign push_pc = pc_q;
    assign op_byte = byte_q;
    assign int_en  = ien;

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_req,
    input logic              vec_valid,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              inta,
    input logic              op_valid,
    input logic              int_en,
    input logic              di_stb
);

    // R1: at most one phase of one sequence is active
    p_one_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_req, vec_valid, inta, op_valid}));

    // R3: only the four restart addresses ever appear
    p_vec_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_addr == ADDR_W'(16'h0024) || vec_addr == ADDR_W'(16'h002C) ||
                       vec_addr == ADDR_W'(16'h0034) || vec_addr == ADDR_W'(16'h003C)));

    // R4: the push is followed by the address
    p_push_then_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |=> vec_valid);

    // R3: the address is always preceded by the push
    p_vec_after_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(push_req));

    // R5: the disable strobe leaves the enable clear
    p_di_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        di_stb |=> !int_en);

    // R6: the enable is already clear when a sequence begins
    p_taken_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req || inta) |-> !int_en);

    // R9: the acknowledge is followed by the fetched byte
    p_ack_then_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inta |=> op_valid);

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_req),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr),
    .inta      (inta),
    .op_valid  (op_valid),
    .int_en    (int_en),
    .di_stb    (di_stb)
);

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 0, edge7_req = 0, lvl6_req = 0, lvl5_req = 0, intr_req = 0;
    logic        ei_stb = 0, di_stb = 0, mask_wr = 0;
    logic [4:0]  mask_wdata = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  data_in = '0;
    logic        push_req, vec_valid, inta, op_valid, int_en;
    logic [15:0] push_pc, vec_addr;
    logic [7:0]  op_byte;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    irq_vec_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .edge7_req(edge7_req),
        .lvl6_req(lvl6_req), .lvl5_req(lvl5_req), .intr_req(intr_req),
        .ei_stb(ei_stb), .di_stb(di_stb), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .pc_in(pc_in), .data_in(data_in), .push_req(push_req), .push_pc(push_pc),
        .vec_valid(vec_valid), .vec_addr(vec_addr), .inta(inta), .op_valid(op_valid),
        .op_byte(op_byte), .int_en(int_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        {trap_req, edge7_req, lvl6_req, lvl5_req, intr_req} = '0;
        {ei_stb, di_stb, mask_wr} = '0;
        mask_wdata = '0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic mwrite(input logic [4:0] d);
        mask_wr = 1; mask_wdata = d;
        @(negedge clk);
        mask_wr = 0; mask_wdata = '0;
    endtask

    task automatic pulse_ei();
        ei_stb = 1;
        @(negedge clk);
        ei_stb = 0;
    endtask

    task automatic quiet(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(!push_req && !inta, req, {push_req, inta}, 0);
        end
    endtask

    function automatic int rst_addr(input int idx);
        return (idx == 4) ? 'h24 : ((idx + 4) * 8 + 4);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Reset state (R5)
        do_reset();
        @(negedge clk);
        chk(int_en == 0, "R5 reset enable", int_en, 0);
        chk({push_req, vec_valid, inta, op_valid} == 0, "R5 reset outputs",
            {push_req, vec_valid, inta, op_valid}, 0);

        // Sweep: every request pattern, mask setting and enable state (R1 R2 R3 R4 R6 R9)
        for (int pat = 0; pat < 32; pat++) begin
            for (int en = 0; en < 2; en++) begin
                for (int m = 0; m < 8; m++) begin
                    int   win;
                    bit   el [5];
                    logic [15:0] pcv;
                    logic [7:0]  dv;
                    do_reset();
                    mwrite(5'(8 + m));
                    if (en == 1) pulse_ei();
                    edge7_req = pat[3];
                    @(negedge clk);
                    pcv = 16'(pat * 97 + m * 13 + en * 7 + 1000);
                    dv  = 8'(pat * 3 + m + en + 1);
                    trap_req = pat[4]; lvl6_req = pat[2]; lvl5_req = pat[1];
                    intr_req = pat[0]; pc_in = pcv; data_in = dv;
                    el[4] = pat[4];
                    el[3] = (en == 1) && !m[2] && pat[3];
                    el[2] = (en == 1) && !m[1] && pat[2];
                    el[1] = (en == 1) && !m[0] && pat[1];
                    el[0] = (en == 1) && pat[0];
                    win = -1;
                    for (int i = 0; i < 5; i++) if (el[i]) win = i;
                    @(negedge clk);
                    {trap_req, edge7_req, lvl6_req, lvl5_req, intr_req} = '0;
                    if (win < 0) begin
                        chk(!push_req && !inta, "R1 nothing eligible", {push_req, inta}, 0);
                        chk(int_en == 1'(en), "R5 enable kept", int_en, en);
                    end else if (win == 0) begin
                        chk(inta && !push_req, "R9 ack without push", {inta, push_req}, 2);
                        chk(int_en == 0, "R6 enable cleared", int_en, 0);
                        @(negedge clk);
                        chk(op_valid && op_byte == dv, "R9 fetched byte", op_byte, dv);
                    end else begin
                        chk(push_req && push_pc == pcv, (win == 4) ? "R2 R4 push" : "R4 push",
                            push_pc, pcv);
                        chk(int_en == 0, "R6 enable cleared", int_en, 0);
                        @(negedge clk);
                        chk(vec_valid && vec_addr == 16'(rst_addr(win)),
                            (win == 4) ? "R2 R3 trap vector" : "R1 R3 winner vector",
                            vec_addr, rst_addr(win));
                    end
                    @(negedge clk);
                end
            end
        end

        // R5: strobes
        do_reset();
        ei_stb = 1; di_stb = 1;
        @(negedge clk);
        ei_stb = 0; di_stb = 0;
        chk(int_en == 0, "R5 clear wins", int_en, 0);
        pulse_ei();
        chk(int_en == 1, "R5 set", int_en, 1);
        di_stb = 1;
        @(negedge clk);
        di_stb = 0;
        chk(int_en == 0, "R5 clear", int_en, 0);

        // R7: reset masks, unarmed write ignored, armed write per line
        do_reset();
        pulse_ei();
        lvl5_req = 1; lvl6_req = 1;
        quiet(2, "R7 reset masked");
        mwrite(5'h01);
        quiet(1, "R7 unarmed write ignored");
        mwrite(5'h0A);
        @(negedge clk);
        lvl5_req = 0; lvl6_req = 0;
        chk(push_req, "R7 level 5 open", push_req, 1);
        @(negedge clk);
        chk(vec_addr == 16'h002C, "R7 level 6 still masked", vec_addr, 'h2C);
        @(negedge clk);

        // R6: enable stays clear until a strobe
        lvl5_req = 1;
        quiet(3, "R6 enable stays clear");
        pulse_ei();
        @(negedge clk);
        lvl5_req = 0;
        chk(push_req, "R6 taken after strobe", push_req, 1);
        repeat (2) @(negedge clk);

        // R6: acceptance beats a coincident set strobe
        pulse_ei();
        lvl5_req = 1; ei_stb = 1;
        @(negedge clk);
        lvl5_req = 0; ei_stb = 0;
        chk(push_req && int_en == 0, "R6 clear beats strobe", int_en, 0);
        repeat (2) @(negedge clk);

        // R10: a level that falls before enable is forgotten
        lvl5_req = 1;
        repeat (2) @(negedge clk);
        lvl5_req = 0;
        @(negedge clk);
        pulse_ei();
        quiet(3, "R10 dropped level not taken");
        chk(int_en == 1, "R10 enable unused", int_en, 1);

        // R8: latched while masked, held, released by unmask, cleared by service
        do_reset();
        mwrite(5'h0C);
        pulse_ei();
        edge7_req = 1;
        @(negedge clk);
        edge7_req = 0;
        quiet(3, "R8 masked latch waits");
        mwrite(5'h08);
        @(negedge clk);
        chk(push_req, "R8 latch released", push_req, 1);
        @(negedge clk);
        chk(vec_addr == 16'h003C, "R8 level 7 vector", vec_addr, 'h3C);
        @(negedge clk);
        pulse_ei();
        quiet(3, "R8 service clears latch");

        // R8: clear bit drops a pending edge without touching masks
        mwrite(5'h0C);
        edge7_req = 1;
        @(negedge clk);
        edge7_req = 0;
        mwrite(5'h10);
        quiet(2, "R8 clear keeps mask");
        mwrite(5'h08);
        quiet(3, "R8 cleared latch");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule